// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block lets a clocked design read and write an external 128K-word by 16-bit asynchronous static RAM that has a separate active-low enable for each byte. A user request carries an address, write data, a two-bit lane mask and a read/write flag. The controller turns it into a sequence of phases on the memory pins. Each phase lasts a set number of clock cycles. The user sees `ready` go low while the access runs. A one-cycle `done` pulse marks the return to idle. For reads, the captured word is presented on `rd_data` in that same cycle.

The memory data bus is split at the block edge into an output word, a per-lane output enable and an input word, so that a pad ring can build the tristate. A write drives only the lanes named in the mask. Single-byte stores therefore need no read-modify-write. Output enable stays inactive for the whole write, and the data drivers turn on only together with write enable. The bus is never driven from both ends.

Every phase length is a parameter counted in clock cycles. To get a value, divide the nanosecond limit by the clock period and round up. Each phase must last at least one cycle.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are high, `mem_dq_oe` is zero, `ready` is high and `done` is low.
- R2: An accepted write runs three phases. First come `WR_SETUP` cycles with chip enable low and write enable high. Next come `WR_PULSE` cycles with both low. Last come `WR_HOLD` cycles with chip enable, write enable and byte enables all high.
- R3: Lane mask bit 0 selects data bits 7:0 and drives `mem_be_n[0]` low. Mask bit 1 selects bits 15:8 and drives `mem_be_n[1]` low. During a write, `mem_dq_oe` equals the mask in the pulse and hold phases and is zero in the setup phase. `mem_dq_o` carries the request data on the selected lanes.
- R4: Output enable stays high throughout a write. The data drivers switch on only in a cycle where write enable is low. `mem_dq_oe` is never nonzero while output enable is low.
- R5: An accepted read holds chip enable and output enable low and write enable high for `RD_ACCESS` cycles, with `mem_be_n` equal to the inverted mask and no lane driven. The input bus is sampled in the last of those cycles.
- R6: `rd_data` holds the memory word on the selected lanes and zero on the unselected lanes.
- R7: After a read, chip enable, output enable and byte enables stay high for `RD_HOLD` cycles before the controller returns to idle.
- R8: `ready` is high only in idle and falls in the cycle after a request is accepted. Requests presented while `ready` is low are ignored. `done` is high for exactly one cycle, which is the first idle cycle after the final hold phase.
- R9: `mem_addr` takes the request address on acceptance and stays stable until the next accepted request.
- R10: A request whose lane mask is zero runs the full phase sequence but leaves both byte enables high and drives no lane, so the memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ready | output | 1 | Idle, request accepted on this edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read word |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_dq_o | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Per-lane driver enable |
| mem_dq_i | input | 16 | Data from the memory |

## Verification
Some properties are checked on every cycle: output enable stays off while write enable is active, no lane is driven while the memory may drive, the drivers switch on only with write enable, write enable stays inside chip enable, and only masked lanes are driven during the pulse. Also checked on every cycle: the pins are quiet when idle, the address holds during a transaction, `ready` falls after acceptance, and `done` lasts a single cycle. The exact length of each phase, the sample point, the masking of the returned lanes and the data that reaches the memory are shown only by the bench's scenarios. The bench runs them against a pin-level memory model and a reference copy of the memory contents.

// File: rtl/asram_pkg.sv
package asram_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WSET,
    PH_WPUL,
    PH_WHLD,
    PH_RACC,
    PH_RHLD
  } phase_e;
endpackage

// File: rtl/asram_rst_sync.sv
module asram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  mask_nx,
  output logic [DATA_W-1:0] rdata_q
);
  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] lane_bits;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[l*8 +: 8] = {8{mask_q[l]}};
  end

  always_comb mask_nx = accept ? req_be : mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= dq_i & lane_bits;
  end
endmodule

// File: rtl/asram_pins.sv
module asram_pins
  import asram_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase_nx,
  input  logic [LANES-1:0] mask_nx,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] be_n,
  output logic [LANES-1:0] dq_oe
);
  logic             ce_n_d, we_n_d, oe_n_d;
  logic [LANES-1:0] be_n_d, dq_oe_d;

  always_comb begin
    ce_n_d  = 1'b1;
    we_n_d  = 1'b1;
    oe_n_d  = 1'b1;
    be_n_d  = '1;
    dq_oe_d = '0;
    unique case (phase_nx)
      PH_WSET: begin
        ce_n_d = 1'b0;
        be_n_d = ~mask_nx;
      end
      PH_WPUL: begin
        ce_n_d  = 1'b0;
        we_n_d  = 1'b0;
        be_n_d  = ~mask_nx;
        dq_oe_d = mask_nx;
      end
      PH_WHLD: dq_oe_d = mask_nx;
      PH_RACC: begin
        ce_n_d = 1'b0;
        oe_n_d = 1'b0;
        be_n_d = ~mask_nx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      be_n  <= '1;
      dq_oe <= '0;
    end else begin
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      be_n  <= be_n_d;
      dq_oe <= dq_oe_d;
    end
  end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WR_SETUP  = 1,
  parameter int unsigned WR_PULSE  = 2,
  parameter int unsigned WR_HOLD   = 1,
  parameter int unsigned RD_ACCESS = 3,
  parameter int unsigned RD_HOLD   = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                ready,
  output logic                done,
  output logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic [DATA_W/8-1:0] mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned MAX_W  = (WR_SETUP > WR_PULSE) ? WR_SETUP : WR_PULSE;
  localparam int unsigned MAX_R  = (RD_ACCESS > RD_HOLD) ? RD_ACCESS : RD_HOLD;
  localparam int unsigned MAX_A  = (MAX_W > MAX_R) ? MAX_W : MAX_R;
  localparam int unsigned MAX_L  = (MAX_A > WR_HOLD) ? MAX_A : WR_HOLD;
  localparam int unsigned CNT_W  = $clog2(MAX_L + 1);

  logic             rst_n_s;
  phase_e           state_q, state_nx;
  logic             expired, accept, capture, finish;
  logic             done_q;
  logic [LANES-1:0] mask_nx;
  logic [CNT_W-1:0] load_val;

  function automatic logic [CNT_W-1:0] phase_len_m1(phase_e p);
    unique case (p)
      PH_WSET: return CNT_W'(WR_SETUP - 1);
      PH_WPUL: return CNT_W'(WR_PULSE - 1);
      PH_WHLD: return CNT_W'(WR_HOLD - 1);
      PH_RACC: return CNT_W'(RD_ACCESS - 1);
      PH_RHLD: return CNT_W'(RD_HOLD - 1);
      default: return '0;
    endcase
  endfunction

  asram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign ready   = (state_q == PH_IDLE);
  assign accept  = ready && req_valid;
  assign capture = (state_q == PH_RACC) && expired;
  assign finish  = ((state_q == PH_WHLD) || (state_q == PH_RHLD)) && expired;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      PH_IDLE: if (req_valid) state_nx = req_write ? PH_WSET : PH_RACC;
      PH_WSET: if (expired)   state_nx = PH_WPUL;
      PH_WPUL: if (expired)   state_nx = PH_WHLD;
      PH_WHLD: if (expired)   state_nx = PH_IDLE;
      PH_RACC: if (expired)   state_nx = PH_RHLD;
      PH_RHLD: if (expired)   state_nx = PH_IDLE;
      default:                state_nx = PH_IDLE;
    endcase
  end

  assign load_val = phase_len_m1(state_nx);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      done_q  <= finish;
    end
  end

  assign done = done_q;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (state_nx != state_q),
    .load_val (load_val),
    .expired  (expired)
  );

  asram_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .dq_i      (mem_dq_i),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_o),
    .mask_nx   (mask_nx),
    .rdata_q   (rd_data)
  );

  asram_pins #(.LANES(LANES)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .phase_nx (state_nx),
    .mask_nx  (mask_nx),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .be_n     (mem_be_n),
    .dq_oe    (mem_dq_oe)
  );
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [LANES-1:0]  mem_dq_oe
);
  assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_no_bus_fight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe != '0) |-> mem_oe_n);

  assert_drive_with_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe != '0) |-> !mem_we_n);

  assert_we_inside_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_lane_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe == ~mem_be_n));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (mem_be_n == '1) && (mem_dq_oe == '0)));

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ready) |=> !ready);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(mem_addr));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W / 8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;
  localparam int WS = 1, WP = 2, WH = 1, RA = 3, RH = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        ready, done;
  logic [15:0] rd_data;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  logic [1:0]  mem_be_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  int n_run = 0;
  int n_fail = 0;

  logic [15:0] sram    [int];
  logic [15:0] exp_mem [int];

  always #10 clk = ~clk;

  asram_ctrl #(.WR_SETUP(WS), .WR_PULSE(WP), .WR_HOLD(WH),
               .RD_ACCESS(RA), .RD_HOLD(RH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ready(ready), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i)
  );

  function automatic logic [15:0] get_word(ref logic [15:0] m [int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  // Pin-level memory model: writes on clock while selected and write-enabled.
  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      logic [15:0] w;
      w = get_word(sram, int'(mem_addr));
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l] && mem_dq_oe[l]) w[l*8 +: 8] = mem_dq_o[l*8 +: 8];
      sram[int'(mem_addr)] = w;
    end
  end

  always_comb begin
    logic [15:0] cur;
    cur = get_word(sram, int'(mem_addr));
    for (int l = 0; l < 2; l++)
      mem_dq_i[l*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
                           ? cur[l*8 +: 8] : 8'hA5;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_pins(input string req);
    chk({mem_ce_n, mem_we_n, mem_oe_n, mem_be_n} == 5'b11111, req,
        {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n}, 5'b11111);
  endtask

  task automatic xfer(input bit wr, input logic [16:0] a, input logic [15:0] d,
                      input logic [1:0] m, input bit junk);
    logic [15:0] lm;
    lm = lane_mask(m);
    @(negedge clk);
    chk(ready == 1'b1, "R8", ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = m;
    @(posedge clk); #1;
    if (junk) begin
      req_write = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~m;
    end else req_valid = 1'b0;
    if (wr) begin
      for (int i = 0; i < WS; i++) begin
        @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b011, "R2", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b011);
        chk(mem_be_n == ~m, "R3", mem_be_n, ~m);
        chk(mem_dq_oe == 2'b00, "R4", mem_dq_oe, 0);
        chk(mem_addr == a, "R9", mem_addr, a);
        chk(ready == 1'b0, "R8", ready, 0);
      end
      for (int i = 0; i < WP; i++) begin
        @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b001, "R2", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b001);
        chk(mem_dq_oe == m, "R3", mem_dq_oe, m);
        chk((mem_dq_o & lm) == (d & lm), "R3", mem_dq_o & lm, d & lm);
        chk(mem_addr == a, "R9", mem_addr, a);
      end
      for (int i = 0; i < WH; i++) begin
        @(negedge clk);
        idle_pins("R2");
        chk(mem_dq_oe == m, "R3", mem_dq_oe, m);
        chk(mem_addr == a, "R9", mem_addr, a);
        if (i == WH - 1) req_valid = 1'b0;
      end
      for (int l = 0; l < 2; l++)
        if (m[l]) begin
          logic [15:0] w;
          w = get_word(exp_mem, int'(a));
          w[l*8 +: 8] = d[l*8 +: 8];
          exp_mem[int'(a)] = w;
        end
    end else begin
      for (int i = 0; i < RA; i++) begin
        @(negedge clk);
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b010, "R5", {mem_ce_n, mem_we_n, mem_oe_n}, 3'b010);
        chk(mem_be_n == ~m, "R5", mem_be_n, ~m);
        chk(mem_dq_oe == 2'b00, "R5", mem_dq_oe, 0);
        chk(mem_addr == a, "R9", mem_addr, a);
      end
      for (int i = 0; i < RH; i++) begin
        @(negedge clk);
        idle_pins("R7");
        chk(ready == 1'b0, "R7", ready, 0);
        if (i == RH - 1) req_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk(ready && done, "R8", {ready, done}, 2'b11);
    chk(mem_dq_oe == 2'b00, "R3", mem_dq_oe, 0);
    if (!wr) chk(rd_data == (get_word(exp_mem, int'(a)) & lm), "R6",
                 rd_data, get_word(exp_mem, int'(a)) & lm);
    @(negedge clk);
    chk(done == 1'b0, "R8", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] pool [8];
    void'($urandom(32'h1F2E3D4C));
    pool[0] = 17'h00000; pool[1] = 17'h1FFFF; pool[2] = 17'h00001; pool[3] = 17'h10000;
    pool[4] = 17'h0ABCD; pool[5] = 17'h15555; pool[6] = 17'h0AAAA; pool[7] = 17'h00FF0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    idle_pins("R1");
    chk(mem_dq_oe == 2'b00 && ready && !done, "R1", {mem_dq_oe, ready, done}, 4'b0010);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R1");
    chk(ready && !done, "R1", {ready, done}, 2'b10);

    // directed: full, low-only, high-only lanes
    xfer(1'b1, pool[1], 16'h1234, 2'b11, 1'b0);
    xfer(1'b0, pool[1], 16'h0000, 2'b11, 1'b0);
    xfer(1'b1, pool[1], 16'hAACC, 2'b01, 1'b1);
    xfer(1'b0, pool[1], 16'h0000, 2'b11, 1'b0);
    xfer(1'b1, pool[1], 16'h5566, 2'b10, 1'b0);
    xfer(1'b0, pool[1], 16'h0000, 2'b01, 1'b1);
    xfer(1'b0, pool[1], 16'h0000, 2'b10, 1'b0);
    // R10 empty mask leaves memory untouched
    xfer(1'b1, pool[1], 16'hFFFF, 2'b00, 1'b0);
    xfer(1'b0, pool[1], 16'h0000, 2'b11, 1'b0);
    chk(rd_data == 16'h55CC, "R10", rd_data, 16'h55CC);
    xfer(1'b0, pool[0], 16'h0000, 2'b00, 1'b0);
    chk(rd_data == 16'h0000, "R10", rd_data, 0);

    for (int k = 0; k < 300; k++) begin
      xfer(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule